// File: doc/BRIEF.md
# Implicit Search Tree Walker

The walker resolves a 16-bit query key against a three-level search tree stored as 256-bit blocks in a single-port memory with one cycle of read latency. The tree keeps no child pointers. Each internal node lists sorted 16-bit boundaries. The walker finds the first boundary strictly above the key, and that position decides which child to visit. The child's block address is then worked out from that position and the fixed sizes of full subtrees. Each subtree under the root takes eighteen blocks: one node and seventeen leaves. Leaves sit one after another behind their parent node.

A caller raises `start` together with a root block address and a key while the walker is idle. The walker then reads the root, the chosen second-level node and the chosen leaf, one block per cycle. It returns the 13-bit data word picked from the leaf, with a one-cycle `done` strobe. A data word of zero marks "no match", and the walker hands it back like any other value. Building trees and managing the memory are left to other logic.

Top module: `tree_walker`

## Requirements
- R1: After reset, `busy`, `done`, `mem_rd` and `result` are all 0.
- R2: In the cycle `start` is high while idle, the walker drives `mem_rd`=1 and `mem_addr`=`root_addr`. It samples `root_addr` and `key` at that clock edge.
- R3: At every level, the branch position is the index (0-based, 0..N) of the first stored boundary strictly greater than the key. If no boundary is greater, the position is N. A boundary equal to the key does not count as greater.
- R4: The second read goes to root + 1 + 18·p, where p is the 0-based branch position found in the root. The root's boundary k occupies bits [16k+15:16k].
- R5: The third read goes to mid + 1 + p, where mid is the second-level node address and p is the branch position found in that node. The layout matches the root's.
- R6: A leaf holds 8 boundaries at bits [16k+15:16k] (k=0..7) and 9 data words at bits [128+13k+12:128+13k] (k=0..8). The result is word p, where p is the leaf's branch position, so word 8 is chosen when no boundary exceeds the key.
- R7: A selected data word of zero is returned as zero, with the normal `done` strobe.
- R8: `done` is high for exactly one cycle. That cycle follows the fourth rising edge, counting the edge that accepted `start` as the first. Exactly three memory reads are issued per lookup, and `result` holds its value until the next lookup completes.
- R9: `busy` is high from the edge that accepts `start` until the edge that ends the `done` cycle. A `start` seen while busy is ignored and causes no extra read and no extra `done`.
- R10: Changing `key` or `root_addr` after the accepting edge does not affect the lookup in flight.
- R11: Leaf bits 255:245 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Lookup request, taken only when idle |
| root_addr | input | 10 | Block address of the tree root |
| key | input | 16 | Query key |
| busy | output | 1 | A lookup is in flight (includes the done cycle) |
| done | output | 1 | One-cycle strobe: result is valid |
| result | output | 13 | Data word selected from the leaf |
| mem_rd | output | 1 | Memory read enable |
| mem_addr | output | 10 | Memory read block address |
| mem_rdata | input | 256 | Block read data, valid one cycle after the read |

## Verification
The address-step assertions assume that each tree fits inside the address space without wrapping, so that a full root subtree of 1 + 18·17 blocks lies above its root. The bench places one tree at a low root address with plenty of room. They also assume that `mem_rdata` in each read state is the block requested in the cycle before. The bench memory model returns exactly that, with one cycle of latency. The priority encoder does not depend on the boundaries being sorted, but the expected branch positions do. The bench therefore fills every node and leaf with strictly increasing boundaries that are evenly spaced, so each expected position can be derived by division.

// File: rtl/tw_pkg.sv
// Shared types for the implicit search tree walker.
// Assumes nothing beyond a standard SystemVerilog toolchain.
package tw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_ROOT,
        ST_READ_MID,
        ST_READ_LEAF,
        ST_DONE
    } walk_state_t;

endpackage

// File: rtl/tw_first_greater.sv
// Finds the 0-based position of the first boundary strictly greater than
// the key among N packed boundaries (boundary k at [KEY_W*k +: KEY_W]).
// Returns N when none is greater. Assumes the boundaries are sorted
// ascending if the result is to mean "interval index".
module tw_first_greater #(
    parameter int KEY_W = 16,
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N + 1)
) (
    input  logic [N*KEY_W-1:0] bounds,
    input  logic [KEY_W-1:0]   key,
    output logic [IDX_W-1:0]   pos
);

    logic [N-1:0] gt;

    // parallel comparators, one per boundary
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign gt[g] = bounds[g*KEY_W +: KEY_W] > key;
    end

    // priority encoder: the lowest set comparator wins
    always_comb begin
        pos = IDX_W'(N);
        for (int k = N - 1; k >= 0; k--) begin
            if (gt[k]) pos = IDX_W'(k);
        end
    end

endmodule

// File: rtl/tw_leaf_pick.sv
// Selects the data word of a leaf block. The leaf has N_EP boundaries in the
// low bits and N_EP+1 data words packed directly above them. The caller
// passes only the used bits, so any bits above them never reach this logic.
module tw_leaf_pick #(
    parameter int KEY_W  = 16,
    parameter int DATA_W = 13,
    parameter int N_EP   = 8,
    parameter int USED_W = N_EP*KEY_W + (N_EP+1)*DATA_W
) (
    input  logic [USED_W-1:0] leaf,
    input  logic [KEY_W-1:0]  key,
    output logic [DATA_W-1:0] data
);

    localparam int WORD_BASE = N_EP * KEY_W;
    localparam int IDX_W     = $clog2(N_EP + 1);

    logic [IDX_W-1:0]  sel;
    logic [DATA_W-1:0] words [N_EP+1];

    tw_first_greater #(.KEY_W(KEY_W), .N(N_EP), .IDX_W(IDX_W)) u_search (
        .bounds (leaf[WORD_BASE-1:0]),
        .key    (key),
        .pos    (sel)
    );

    // unpack the data words
    for (genvar g = 0; g <= N_EP; g++) begin : g_word
        assign words[g] = leaf[WORD_BASE + g*DATA_W +: DATA_W];
    end

    // word multiplexer driven by the branch position
    always_comb begin
        data = '0;
        for (int k = 0; k <= N_EP; k++) begin
            if (sel == IDX_W'(k)) data = words[k];
        end
    end

endmodule

// File: rtl/tree_walker.sv
// Walks an implicit three-level search tree: root node, second-level node,
// then leaf, one block read per level. Child addresses are computed from the
// branch position and the fixed full-subtree size. Assumes a memory with one
// cycle of read latency whose data is valid in the cycle after mem_rd, and
// trees that do not wrap around the address space.
module tree_walker
    import tw_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int KEY_W   = 16,
    parameter int DATA_W  = 13,
    parameter int BLK_W   = 256,
    parameter int LEAF_EP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] root_addr,
    input  logic [KEY_W-1:0]  key,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [BLK_W-1:0]  mem_rdata
);

    localparam int N_NODE   = BLK_W / KEY_W;
    localparam int IDX_W    = $clog2(N_NODE + 1);
    localparam int MID_SPAN = N_NODE + 2;
    localparam int LEAF_USE = LEAF_EP*KEY_W + (LEAF_EP+1)*DATA_W;

    walk_state_t       state;
    logic [KEY_W-1:0]  key_q;
    logic [ADDR_W-1:0] cur_q;
    logic [DATA_W-1:0] result_q;
    logic [IDX_W-1:0]  node_idx;
    logic [DATA_W-1:0] leaf_data;

    tw_first_greater #(.KEY_W(KEY_W), .N(N_NODE), .IDX_W(IDX_W)) u_node (
        .bounds (mem_rdata[N_NODE*KEY_W-1:0]),
        .key    (key_q),
        .pos    (node_idx)
    );

    tw_leaf_pick #(.KEY_W(KEY_W), .DATA_W(DATA_W), .N_EP(LEAF_EP),
                   .USED_W(LEAF_USE)) u_leaf (
        .leaf (mem_rdata[LEAF_USE-1:0]),
        .key  (key_q),
        .data (leaf_data)
    );

    // read request: root on start, then the computed child addresses
    always_comb begin
        mem_rd   = 1'b0;
        mem_addr = '0;
        case (state)
            ST_IDLE: begin
                mem_rd   = start;
                mem_addr = root_addr;
            end
            ST_READ_ROOT: begin
                mem_rd   = 1'b1;
                mem_addr = cur_q + ADDR_W'(1)
                         + ADDR_W'(MID_SPAN) * ADDR_W'(node_idx);
            end
            ST_READ_MID: begin
                mem_rd   = 1'b1;
                mem_addr = cur_q + ADDR_W'(1) + ADDR_W'(node_idx);
            end
            default: begin
                mem_rd   = 1'b0;
                mem_addr = '0;
            end
        endcase
    end

    // walk sequencer and result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            key_q    <= '0;
            cur_q    <= '0;
            result_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        key_q <= key;
                        cur_q <= root_addr;
                        state <= ST_READ_ROOT;
                    end
                end
                ST_READ_ROOT: begin
                    cur_q <= mem_addr;
                    state <= ST_READ_MID;
                end
                ST_READ_MID: begin
                    cur_q <= mem_addr;
                    state <= ST_READ_LEAF;
                end
                ST_READ_LEAF: begin
                    result_q <= leaf_data;
                    state    <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy   = (state != ST_IDLE);
    assign done   = (state == ST_DONE);
    assign result = result_q;

    // ---------------- assertions ----------------
    logic [ADDR_W-1:0] step_w;
    assign step_w = mem_addr - cur_q;

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_no_read_late_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ_LEAF || done) |-> !mem_rd);

    p_start_taken_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !done));

    p_no_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    p_root_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ_ROOT) |-> (mem_rd
            && step_w <= ADDR_W'(1 + MID_SPAN*N_NODE)
            && ((step_w - ADDR_W'(1)) % ADDR_W'(MID_SPAN)) == '0));

    p_leaf_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ_MID) |-> (mem_rd
            && step_w >= ADDR_W'(1) && step_w <= ADDR_W'(N_NODE + 1)));

endmodule

// File: tb/tree_walker_bench.sv
`timescale 1ns/1ps
module tree_walker_bench;

    localparam int ADDR_W = 10;
    localparam int ROOT   = 37;
    localparam int NV     = 8;

    // stimulus table: key and expected branch positions root/mid/leaf
    localparam logic [15:0] VK [NV] = '{16'h0000, 16'h0F00, 16'hFFFF, 16'h1234,
                                        16'h1180, 16'h0018, 16'h8000, 16'h22B0};
    localparam int VJ [NV] = '{0, 1, 16, 1, 1, 0, 8, 2};
    localparam int VM [NV] = '{0, 0, 16, 3, 2, 0, 9, 5};
    localparam int VL [NV] = '{0, 0, 8, 6, 8, 1, 1, 3};

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start;
    logic [ADDR_W-1:0] root_i;
    logic [15:0]       key_i;
    logic              busy, done, mem_rd;
    logic [12:0]       result;
    logic [ADDR_W-1:0] mem_addr;
    logic [255:0]      mem_rdata;

    logic [255:0]      mem [0:(1<<ADDR_W)-1];
    int                rd_cnt;
    int                rd_log [4];
    int                n_chk = 0;
    int                n_bad = 0;

    always #2 clk = ~clk;

    tree_walker u_tree_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .root_addr(root_i),
        .key(key_i), .busy(busy), .done(done), .result(result),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    // memory model: one cycle read latency, read addresses logged
    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= mem[mem_addr];
            if (rd_cnt < 4) rd_log[rd_cnt] <= int'(mem_addr);
            rd_cnt <= rd_cnt + 1;
        end
    end

    function automatic int fdat(input int j, input int m, input int k);
        if (j == 2 && m == 5 && k == 3) return 0;
        return (j*17 + m)*9 + k + 1;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one lookup; glitch drives a second start and new inputs while busy
    task automatic lookup(input logic [15:0] k, input int j, input int m,
                          input int l, input bit glitch);
        int lat;
        int mid;
        mid = ROOT + 1 + 18*j;
        rd_cnt = 0;
        start = 1'b1; key_i = k; root_i = ADDR_W'(ROOT);
        #1;
        chk("R2 mem_rd", int'(mem_rd), 1);
        chk("R2 mem_addr", int'(mem_addr), ROOT);
        @(negedge clk); lat = 1;
        if (glitch) begin
            start = 1'b1; key_i = ~k; root_i = ADDR_W'(ROOT + 3);
        end else start = 1'b0;
        while (!done && lat < 12) begin
            @(negedge clk); lat++; start = 1'b0;
        end
        chk("R8 latency", lat, 4);
        chk("R6 result", int'(result), fdat(j, m, l));
        chk("R4 mid read addr", rd_log[1], mid);
        chk("R5 leaf read addr", rd_log[2], mid + 1 + m);
        chk("R3 root read addr", rd_log[0], ROOT);
        @(negedge clk);
        chk("R8 done one cycle", int'(done), 0);
        chk("R9 idle after", int'(busy), 0);
        chk("R8 read count", rd_cnt, 3);
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        // build memory: evenly spaced sorted boundaries, high leaf bits set
        for (int a = 0; a < (1<<ADDR_W); a++) mem[a] = '0;
        for (int k = 0; k < 16; k++) mem[ROOT][16*k +: 16] = 16'(16'h0F00*(k+1));
        for (int j = 0; j <= 16; j++) begin
            int mid;
            mid = ROOT + 1 + 18*j;
            for (int k = 0; k < 16; k++)
                mem[mid][16*k +: 16] = 16'(j*16'h0F00 + 16'h00E0*(k+1));
            for (int m = 0; m <= 16; m++) begin
                logic [255:0] b;
                b = '0;
                b[255:245] = '1;  // R11: must not affect result
                for (int k = 0; k < 8; k++)
                    b[16*k +: 16] = 16'(j*16'h0F00 + m*16'h00E0 + 16'h0018*(k+1));
                for (int k = 0; k < 9; k++)
                    b[128 + 13*k +: 13] = 13'(fdat(j, m, k));
                mem[mid + 1 + m] = b;
            end
        end
        rd_cnt = 0;
        mem_rdata = '0;
        start = 1'b0; key_i = '0; root_i = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 result", int'(result), 0);
        chk("R1 mem_rd", int'(mem_rd), 0);

        // table walk: R3 R4 R5 R6 R7 (vector 7 selects a zero word) R11
        for (int v = 0; v < NV; v++) lookup(VK[v], VJ[v], VM[v], VL[v], 1'b0);

        // R9 and R10: start plus changed key/root while busy are ignored
        lookup(16'h1234, 1, 3, 6, 1'b1);
        // R7: zero result directly
        lookup(16'h22B0, 2, 5, 3, 1'b0);
        chk("R7 zero passthrough", int'(result), 0);
        // R8: result holds while idle
        repeat (3) @(negedge clk);
        chk("R8 result held", int'(result), 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule